// File: doc/BRIEF.md
# Hit-Count Threshold Trigger Bank

This block decides, once per beam clock, whether enough discriminator hits are present to fire a trigger. Each channel takes a 36-bit hit vector, where each bit is one tile-sum threshold result. It counts the set bits and compares that number with a 6-bit programmable threshold. The channel raises its trigger bit when the count is greater than or equal to the threshold. Four channels sit side by side and share nothing except the clock and the reset. Each channel has its own hit vector and its own threshold, so the bank can serve four separate trigger classes in parallel.

Each channel first registers its hit vector. It then cuts the registered vector into twelve groups of three bits. Each group becomes a 2-bit count. A staged adder tree sums the twelve counts into a 6-bit total. The compare result is registered. The trigger is therefore valid one beam clock after the hit vector is captured. The threshold is not registered inside the block: it is read from a steady configuration source at the edge that loads the output register.

The data path has no handshake. Each beam clock is a new sample, and the block accepts one per cycle without back-pressure. The nominal beam clock is 10 MHz.

Top module: `trig_bank`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears the hit register and the trigger register of every channel. While `rst` is high, `trig_o` reads 4'b0000. On the first edge after `rst` is released, each trigger is computed from the cleared (all-zero) hit register.
- R2: Hits present at clock edge k are reflected on `trig_o` after edge k+1 and not before, giving one cycle of latency after capture.
- R3: Channel c drives `trig_o[c]` high exactly when the number of set bits in `hits_i[36c+35:36c]` is greater than or equal to the unsigned value `thr_i[6c+5:6c]`.
- R4: A threshold of 0 drives the channel's trigger high on every cycle after reset, even when no hits are present.
- R5: Any threshold from 37 to 63 keeps the channel's trigger low, even with all 36 hits set. A threshold of 36 fires only when all 36 hits are set.
- R6: Channels are independent: the hit vector and threshold of one channel have no effect on another channel's trigger.
- R7: Every one of the 36 bit positions of a channel is counted exactly once, whichever 3-bit group it falls in.
- R8: A threshold change with the hits held steady takes effect on `trig_o` after the very next clock edge.
- R9: The bank accepts a new hit vector on every cycle. Back-to-back vectors produce back-to-back results, in the same order, each one cycle after its capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beam clock |
| rst | input | 1 | Synchronous reset, active high |
| hits_i | input | 144 | Hit vectors; channel c uses bits [36c+35:36c] |
| thr_i | input | 24 | Count thresholds; channel c uses bits [6c+5:6c], unsigned |
| trig_o | output | 4 | Registered trigger; bit c belongs to channel c |

## Verification
The assertions assume that `thr_i` is stable around each clock edge, because the threshold is sampled straight into the output register. They also assume the reset is held for at least one edge before any check starts. The bench meets both assumptions by changing `hits_i`, `thr_i` and `rst` only on the falling clock edge. It holds reset for several cycles at the start. The count-exactness and latency properties compare the tree's result with an independent population count of the captured vector. This holds for any hit pattern, so the stimulus covers single bits at every position, complementary patterns and dense back-to-back streams.

// File: rtl/hct_pkg.sv
package hct_pkg;
  localparam int HCT_HITS   = 36;
  localparam int HCT_GROUP  = 3;
  localparam int HCT_THR_W  = 6;
  localparam int HCT_N_CH   = 4;
  localparam int HCT_SUM_W  = $clog2(HCT_HITS + 1);
  localparam int HCT_GCNT_W = $clog2(HCT_GROUP + 1);
endpackage

// File: rtl/hct_group_count.sv
module hct_group_count #(
  parameter int GROUP_W = 3,
  parameter int CNT_W   = $clog2(GROUP_W + 1)
) (
  input  logic [GROUP_W-1:0] bits_i,
  output logic [CNT_W-1:0]   cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < GROUP_W; i++) begin
      cnt_o = cnt_o + CNT_W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/hct_adder_tree.sv
module hct_adder_tree #(
  parameter int N_IN  = 12,
  parameter int IN_W  = 2,
  parameter int SUM_W = 6
) (
  input  logic [N_IN*IN_W-1:0] terms_i,
  output logic [SUM_W-1:0]     sum_o
);
  localparam int LV = (N_IN > 1) ? $clog2(N_IN) : 0;

  for (genvar l = 0; l <= LV; l++) begin : g_lv
    localparam int CNT = (N_IN + (1 << l) - 1) >> l;
    logic [SUM_W-1:0] v [CNT];
    if (l == 0) begin : g_leaf
      for (genvar i = 0; i < CNT; i++) begin : g_t
        assign v[i] = SUM_W'(terms_i[i*IN_W +: IN_W]);
      end
    end else begin : g_node
      localparam int PCNT = (N_IN + (1 << (l - 1)) - 1) >> (l - 1);
      for (genvar i = 0; i < CNT; i++) begin : g_n
        if (2*i + 1 < PCNT) begin : g_add
          assign v[i] = g_lv[l-1].v[2*i] + g_lv[l-1].v[2*i+1];
        end else begin : g_pass
          assign v[i] = g_lv[l-1].v[2*i];
        end
      end
    end
  end

  assign sum_o = g_lv[LV].v[0];
endmodule

// File: rtl/hct_channel.sv
module hct_channel #(
  parameter int N_HITS  = 36,
  parameter int GROUP_W = 3,
  parameter int THR_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_HITS-1:0] hits_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic              trig_o
);
  localparam int N_GRP  = (N_HITS + GROUP_W - 1) / GROUP_W;
  localparam int GCNT_W = $clog2(GROUP_W + 1);
  localparam int SUM_W  = $clog2(N_HITS + 1);
  localparam int CMP_W  = (SUM_W > THR_W) ? SUM_W : THR_W;

  logic [N_HITS-1:0]        hits_q;
  logic [N_GRP*GROUP_W-1:0] padded;
  logic [N_GRP*GCNT_W-1:0]  grp_cnt;
  logic [SUM_W-1:0]         total;
  logic                     trig_q;

  always_ff @(posedge clk) begin
    if (rst) hits_q <= '0;
    else     hits_q <= hits_i;
  end

  always_comb begin
    padded = '0;
    padded[N_HITS-1:0] = hits_q;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    hct_group_count #(.GROUP_W(GROUP_W), .CNT_W(GCNT_W)) u_gc (
      .bits_i (padded[g*GROUP_W +: GROUP_W]),
      .cnt_o  (grp_cnt[g*GCNT_W +: GCNT_W])
    );
  end

  hct_adder_tree #(.N_IN(N_GRP), .IN_W(GCNT_W), .SUM_W(SUM_W)) u_tree (
    .terms_i (grp_cnt),
    .sum_o   (total)
  );

  always_ff @(posedge clk) begin
    if (rst) trig_q <= 1'b0;
    else     trig_q <= (CMP_W'(total) >= CMP_W'(thr_i));
  end

  assign trig_o = trig_q;

  // R1: reset clears the trigger register
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> !trig_q);

  // R7: tree total equals an independent population count
  a_r7_count_exact: assert property (@(posedge clk) disable iff (rst)
    int'(total) == $countones(hits_q));

  // R2 / R3: trigger follows captured count and threshold one edge later
  a_r2_latency_compare: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (trig_q == ($countones($past(hits_q)) >= int'($past(thr_i)))));

  // R4: zero threshold always fires
  a_r4_zero_fires: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(thr_i) == '0) |-> trig_q);

  // R5: threshold beyond the input count never fires
  a_r5_over_silent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && int'($past(thr_i)) > N_HITS) |-> !trig_q);
endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import hct_pkg::*;
#(
  parameter int N_CH    = HCT_N_CH,
  parameter int N_HITS  = HCT_HITS,
  parameter int GROUP_W = HCT_GROUP,
  parameter int THR_W   = HCT_THR_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_CH*N_HITS-1:0]   hits_i,
  input  logic [N_CH*THR_W-1:0]    thr_i,
  output logic [N_CH-1:0]          trig_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    hct_channel #(.N_HITS(N_HITS), .GROUP_W(GROUP_W), .THR_W(THR_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .hits_i (hits_i[c*N_HITS +: N_HITS]),
      .thr_i  (thr_i[c*THR_W +: THR_W]),
      .trig_o (trig_o[c])
    );
  end

  // R6: a channel with zero threshold fires regardless of its neighbours
  a_r6_ch0_independent: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(thr_i[THR_W-1:0]) == '0) |-> trig_o[0]);
endmodule

// File: tb/trig_bank_tb.sv
module trig_bank_tb;
  localparam int NC = 4;
  localparam int NH = 36;
  localparam int TW = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NC*NH-1:0] hits_v = '0;
  logic [NC*TW-1:0] thr_v  = '0;
  logic [NC-1:0]    trig;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  trig_bank u_dut (
    .clk    (clk),
    .rst    (rst),
    .hits_i (hits_v),
    .thr_i  (thr_v),
    .trig_o (trig)
  );

  function automatic int pop(input logic [NH-1:0] v);
    int n = 0;
    for (int i = 0; i < NH; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic logic [NH-1:0] spread(input int k);
    logic [NH-1:0] v = '0;
    for (int i = 0; i < k; i++) v[(i*7) % NH] = 1'b1;
    return v;
  endfunction

  function automatic logic [NC-1:0] expect_now();
    logic [NC-1:0] e;
    for (int c = 0; c < NC; c++)
      e[c] = pop(hits_v[c*NH +: NH]) >= int'(thr_v[c*TW +: TW]);
    return e;
  endfunction

  task automatic chk(input string req, input logic [NC-1:0] exp);
    n_checks++;
    if (trig !== exp) begin
      n_fail++;
      $display("FAIL %s: trig=%b expected=%b", req, trig, exp);
    end
  endtask

  task automatic set_ch(input int c, input logic [NH-1:0] h, input int t);
    hits_v[c*NH +: NH] = h;
    thr_v[c*TW +: TW]  = TW'(t);
  endtask

  // drive at current negedge, check two negedges later
  task automatic settle_check(input string req);
    logic [NC-1:0] e;
    e = expect_now();
    @(negedge clk);
    @(negedge clk);
    chk(req, e);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    hits_v = '1;
    thr_v = '0;
    repeat (3) @(negedge clk);
    chk("R1 during reset", 4'b0000);
    hits_v = '0;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after release", 4'b1111);
  endtask

  task automatic t_patterns;
    int ks[5] = '{1, 5, 17, 35, 36};
    foreach (ks[j]) begin
      set_ch(0, spread(ks[j]), ks[j]);
      set_ch(1, spread(ks[j] - 1), ks[j]);
      set_ch(2, ~spread(ks[j]), NH - ks[j]);
      set_ch(3, ~spread(ks[j] - 1), NH - ks[j] + 2);
      settle_check("R3 count vs threshold");
    end
  endtask

  task automatic t_thr_zero;
    hits_v = '0;
    thr_v = '0;
    settle_check("R4 zero threshold");
  endtask

  task automatic t_thr_over;
    hits_v = '1;
    set_ch(0, '1, 37);
    set_ch(1, '1, 63);
    set_ch(2, '1, 36);
    set_ch(3, ~spread(1), 36);
    settle_check("R5 threshold above count");
  endtask

  task automatic t_positions;
    for (int p = 0; p < NH; p++) begin
      logic [NH-1:0] one = '0;
      one[p] = 1'b1;
      set_ch(0, one, 1);
      set_ch(1, one, 2);
      set_ch(2, ~one, 35);
      set_ch(3, ~one, 36);
      settle_check("R7 single bit position");
    end
  endtask

  task automatic t_channels;
    set_ch(0, spread(10), 10);
    set_ch(1, spread(10), 11);
    set_ch(2, '0, 1);
    set_ch(3, spread(20), 3);
    settle_check("R6 independent channels");
    set_ch(1, '1, 1);
    set_ch(3, '0, 63);
    settle_check("R6 neighbour change");
  endtask

  task automatic t_latency;
    hits_v = '0;
    thr_v = {NC{TW'(1)}};
    settle_check("R2 idle");
    hits_v = '1;
    @(negedge clk);
    chk("R2 not before second edge", 4'b0000);
    @(negedge clk);
    chk("R2 after second edge", 4'b1111);
    hits_v = '0;
    @(negedge clk);
    chk("R2 falling held", 4'b1111);
    @(negedge clk);
    chk("R2 falling", 4'b0000);
  endtask

  task automatic t_thr_change;
    for (int c = 0; c < NC; c++) set_ch(c, spread(12), 13);
    settle_check("R8 before change");
    thr_v = {NC{TW'(12)}};
    @(negedge clk);
    chk("R8 threshold after one edge", 4'b1111);
  endtask

  task automatic t_stream;
    logic [NC-1:0] exp_q [10];
    thr_v = {NC{TW'(18)}};
    for (int i = 0; i < 10; i++) begin
      if (i >= 2) chk("R9 stream", exp_q[i-2]);
      if (i < 8) begin
        for (int c = 0; c < NC; c++)
          hits_v[c*NH +: NH] = spread(((i + c) % 2 == 0) ? 18 + c : 17 - c);
        exp_q[i] = expect_now();
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset_mid;
    hits_v = '1;
    thr_v = {NC{TW'(36)}};
    settle_check("R1 setup");
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset mid run", 4'b0000);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 input register cleared", 4'b0000);
    @(negedge clk);
    chk("R1 recovery", 4'b1111);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_patterns();
    t_thr_zero();
    t_thr_over();
    t_positions();
    t_channels();
    t_latency();
    t_thr_change();
    t_stream();
    t_reset_mid();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: trig=%b expected=completion", trig);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule